// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Register Bank

This block is one general-purpose I/O port of sixteen pins. Software reaches it through a word-wide register bus. The bank holds these registers:

- pin direction and mode
- output drive type (push-pull or open-drain)
- drive speed
- pull resistor selection
- output data
- lock
- two alternate-function selection words
- analog switch

Output data can also be changed atomically. A set/clear word changes it, with set taking priority over clear. A clear-only word also changes it. Both of these words read back as zero.

Drive speed, lock, alternate-function and analog-switch values are stored and read back only. They have no effect on the pins.

A pin resolver turns the configuration, the output data and the external pad drivers into the level of each pin. That level can be read at the input-data register and is also presented on `pad_level`.

External drivers reach a pin through a one-pin-per-cycle drive port. A drive that would fight an output stage is refused. When the mode or output-type register changes, every pad driver that now conflicts with its pin's output stage is cut off. A release mask detaches drivers.

A pin that has no driver and no pull keeps its last resolved level.

The bus has no back-pressure. An access is taken in every cycle in which `bus_sel` is high. Read data is combinational from the stored values. Writes land on the clock edge that samples the strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset, the mode, speed and pull registers hold the values of parameters `MODE_RST`, `SPEED_RST` and `PULL_RST`. Every other register reads 0, and `bus_err` is 0.
- R2: The register map is fixed by word offset:
  - mode 0x00
  - drive type 0x04
  - speed 0x08
  - pull 0x0C
  - input level 0x10
  - output data 0x14
  - set/clear 0x18
  - lock 0x1C
  - alternate-function low 0x20
  - alternate-function high 0x24
  - clear 0x28
  - analog switch 0x2C

  Mode, speed, pull and both alternate-function words store all 32 bits. Drive type, output data, lock and analog switch keep only bits 15:0; bits 31:16 read 0.
- R3: A write to 0x18 clears the output-data bits selected by wdata[31:16], then sets the bits selected by wdata[15:0]. Set wins when both bits of a pin are 1. A read of 0x18 returns 0.
- R4: A write to 0x28 clears the output-data bits selected by wdata[15:0]. A read of 0x28 returns 0.
- R5: The input-level register at 0x10 is read-only. A write to it changes no register.
- R6: An access to an unmapped offset (0x30 and above), or to an address whose bits 1:0 are not 00, reads 0 and writes nothing. Such an access raises `bus_err` for exactly the one cycle after the edge that samples it.
- R7: The field encodings are as follows:
  - Mode field 2n+1:2n equal to 01 makes pin n an output. Any other mode value is an input.
  - Drive-type bit n equal to 1 makes the output open-drain.
  - Pull field 01 is pull-up and 10 is pull-down.

  The level of an output pin is decided in this order:
  - A push-pull output takes its output-data bit.
  - An open-drain output with output-data 0 reads 0.
  - An open-drain output with output-data 1 reads 0 if an attached driver holds it low. Otherwise pull-up gives 1 and pull-down gives 0.
  - With none of these, the pin keeps its level.
- R8: An input pin with an attached driver reads the driver's level. Without a driver, pull-up gives 1 and pull-down gives 0. With no pull, the pin keeps its last level. The level register updates on the edge after the state it depends on changes.
- R9: A pad drive is refused, and leaves the pin detached, when the pin is an output, unless the pin is open-drain and the drive is low.
- R10: On the edge after a write to the mode or drive-type register, a pad driver is detached from every output pin that is push-pull or that it holds high.
- R11: A pin whose `pad_release` bit is 1 loses its pad driver at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| bus_err | output | 1 | One-cycle flag for an illegal access |
| pad_drv_valid | input | 1 | External pad drive event |
| pad_drv_pin | input | 4 | Pin index of the drive event |
| pad_drv_level | input | 1 | Level applied by the pad driver |
| pad_release | input | 16 | Per-pin driver detach mask |
| pad_level | output | 16 | Resolved pin levels (same as input-level register) |

## Verification
The bench overrides all three reset-value parameters with non-zero patterns. This makes the reset check tell parameter-loaded registers apart from zeroed ones.

The override puts pull-up on pins 1 and 3 and pull-down on pin 2. Because of that, the first input-level read already exercises pull resolution on pins with no driver.

With `AW` at its default of 10, an address far above the map (0x3FC) is reachable. This lets the error path be driven both by misalignment and by an unmapped offset.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PINS  = 16;
  localparam int DW    = 32;
  localparam int PIN_W = $clog2(PINS);
  localparam int NREGS = 12;

  typedef enum logic [3:0] {
    RG_MODE   = 4'd0,
    RG_OTYPE  = 4'd1,
    RG_SPEED  = 4'd2,
    RG_PULL   = 4'd3,
    RG_IN     = 4'd4,
    RG_OUT    = 4'd5,
    RG_SETCLR = 4'd6,
    RG_LOCK   = 4'd7,
    RG_AFLO   = 4'd8,
    RG_AFHI   = 4'd9,
    RG_CLR    = 4'd10,
    RG_ASW    = 4'd11,
    RG_NONE   = 4'd15
  } reg_sel_e;

  localparam logic [1:0] MD_OUT  = 2'b01;
  localparam logic [1:0] PL_UP   = 2'b01;
  localparam logic [1:0] PL_DOWN = 2'b10;
endpackage

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_pkg::*;
#(
  parameter int          AW        = 10,
  parameter logic [31:0] MODE_RST  = 32'h0,
  parameter logic [31:0] SPEED_RST = 32'h0,
  parameter logic [31:0] PULL_RST  = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  input  logic [PINS-1:0] idr_i,
  output logic [DW-1:0]   mode_o,
  output logic [PINS-1:0] otype_o,
  output logic [DW-1:0]   pull_o,
  output logic [PINS-1:0] odr_o,
  output logic            cfg_chg_o
);
  localparam logic [AW-1:0] MAP_END = AW'(4 * NREGS);

  reg_sel_e        rsel;
  logic            wr;
  logic [DW-1:0]   mode_q, speed_q, pull_q, aflo_q, afhi_q;
  logic [PINS-1:0] otype_q, odr_q, lock_q, asw_q;
  logic            err_q, chg_q;

  always_comb begin
    rsel = RG_NONE;
    if (bus_addr[1:0] == 2'b00 && bus_addr < MAP_END)
      rsel = reg_sel_e'(bus_addr[5:2]);
  end

  assign wr = bus_sel && bus_we && (rsel != RG_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      speed_q <= SPEED_RST;
      pull_q  <= PULL_RST;
      aflo_q  <= '0;
      afhi_q  <= '0;
      otype_q <= '0;
      odr_q   <= '0;
      lock_q  <= '0;
      asw_q   <= '0;
      err_q   <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      err_q <= bus_sel && (rsel == RG_NONE);
      chg_q <= wr && (rsel == RG_MODE || rsel == RG_OTYPE);
      if (wr) begin
        case (rsel)
          RG_MODE:   mode_q  <= bus_wdata;
          RG_OTYPE:  otype_q <= bus_wdata[PINS-1:0];
          RG_SPEED:  speed_q <= bus_wdata;
          RG_PULL:   pull_q  <= bus_wdata;
          RG_OUT:    odr_q   <= bus_wdata[PINS-1:0];
          RG_SETCLR: odr_q   <= (odr_q & ~bus_wdata[2*PINS-1:PINS]) | bus_wdata[PINS-1:0];
          RG_LOCK:   lock_q  <= bus_wdata[PINS-1:0];
          RG_AFLO:   aflo_q  <= bus_wdata;
          RG_AFHI:   afhi_q  <= bus_wdata;
          RG_CLR:    odr_q   <= odr_q & ~bus_wdata[PINS-1:0];
          RG_ASW:    asw_q   <= bus_wdata[PINS-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (rsel)
      RG_MODE:  bus_rdata = mode_q;
      RG_OTYPE: bus_rdata = DW'(otype_q);
      RG_SPEED: bus_rdata = speed_q;
      RG_PULL:  bus_rdata = pull_q;
      RG_IN:    bus_rdata = DW'(idr_i);
      RG_OUT:   bus_rdata = DW'(odr_q);
      RG_LOCK:  bus_rdata = DW'(lock_q);
      RG_AFLO:  bus_rdata = aflo_q;
      RG_AFHI:  bus_rdata = afhi_q;
      RG_ASW:   bus_rdata = DW'(asw_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign bus_err   = err_q;
  assign mode_o    = mode_q;
  assign otype_o   = otype_q;
  assign pull_o    = pull_q;
  assign odr_o     = odr_q;
  assign cfg_chg_o = chg_q;

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && rsel == RG_NONE) |=> bus_err);
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel) |=> !bus_err);
  assert_in_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && rsel == RG_IN) |=> (odr_q == $past(odr_q)));
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rsel == RG_SETCLR) |=>
      ((odr_q & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));
endmodule

// File: rtl/gpio_link.sv
module gpio_link
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    mode_i,
  input  logic [PINS-1:0]  otype_i,
  input  logic             cfg_chg_i,
  input  logic             drv_valid_i,
  input  logic [PIN_W-1:0] drv_pin_i,
  input  logic             drv_level_i,
  input  logic [PINS-1:0]  release_i,
  output logic [PINS-1:0]  conn_o,
  output logic [PINS-1:0]  high_o
);
  logic [PINS-1:0] conn_q, high_q, is_out, conflict;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic accept;
    assign is_out[p]   = (mode_i[2*p +: 2] == MD_OUT);
    assign conflict[p] = is_out[p] && (!otype_i[p] || high_q[p]);
    assign accept = drv_valid_i && (drv_pin_i == PIN_W'(p)) &&
                    !(is_out[p] && !(otype_i[p] && !drv_level_i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        conn_q[p] <= 1'b0;
        high_q[p] <= 1'b0;
      end else if (release_i[p] || (cfg_chg_i && conn_q[p] && conflict[p])) begin
        conn_q[p] <= 1'b0;
      end else if (accept) begin
        conn_q[p] <= 1'b1;
        high_q[p] <= drv_level_i;
      end
    end
  end

  assign conn_o = conn_q;
  assign high_o = high_q;

  assert_refuse_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid_i && is_out[drv_pin_i] && !(otype_i[drv_pin_i] && !drv_level_i) &&
     release_i == '0 && !cfg_chg_i) |=> (conn_q == $past(conn_q)));
  assert_cfg_detach_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg_i |=> ((conn_q & $past(conflict)) == '0));
  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i != '0) |=> ((conn_q & $past(release_i)) == '0));
endmodule

// File: rtl/gpio_resolver.sv
module gpio_resolver
  import gpio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   mode_i,
  input  logic [PINS-1:0] otype_i,
  input  logic [DW-1:0]   pull_i,
  input  logic [PINS-1:0] odr_i,
  input  logic [PINS-1:0] conn_i,
  input  logic [PINS-1:0] high_i,
  output logic [PINS-1:0] idr_o
);
  logic [PINS-1:0] idr_q, pp_mask;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic       out, up, dn, nxt;
    assign out = (mode_i[2*p +: 2] == MD_OUT);
    assign up  = (pull_i[2*p +: 2] == PL_UP);
    assign dn  = (pull_i[2*p +: 2] == PL_DOWN);
    assign pp_mask[p] = out && !otype_i[p];

    always_comb begin
      nxt = idr_q[p];
      if (out) begin
        if (!otype_i[p])                 nxt = odr_i[p];
        else if (!odr_i[p])              nxt = 1'b0;
        else if (conn_i[p] && !high_i[p]) nxt = 1'b0;
        else if (up)                     nxt = 1'b1;
        else if (dn)                     nxt = 1'b0;
      end else begin
        if (conn_i[p])                   nxt = high_i[p];
        else if (up)                     nxt = 1'b1;
        else if (dn)                     nxt = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idr_q[p] <= 1'b0;
      else        idr_q[p] <= nxt;
    end
  end

  assign idr_o = idr_q;

  assert_pushpull_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((idr_q & $past(pp_mask)) == ($past(odr_i) & $past(pp_mask))));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int          AW        = 10,
  parameter logic [31:0] MODE_RST  = 32'h0,
  parameter logic [31:0] SPEED_RST = 32'h0,
  parameter logic [31:0] PULL_RST  = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_err,
  input  logic             pad_drv_valid,
  input  logic [PIN_W-1:0] pad_drv_pin,
  input  logic             pad_drv_level,
  input  logic [PINS-1:0]  pad_release,
  output logic [PINS-1:0]  pad_level
);
  logic [DW-1:0]   mode, pull;
  logic [PINS-1:0] otype, odr, conn, high, idr;
  logic            cfg_chg;

  gpio_regbank #(
    .AW(AW), .MODE_RST(MODE_RST), .SPEED_RST(SPEED_RST), .PULL_RST(PULL_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .idr_i(idr), .mode_o(mode), .otype_o(otype), .pull_o(pull),
    .odr_o(odr), .cfg_chg_o(cfg_chg)
  );

  gpio_link u_link (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .otype_i(otype),
    .cfg_chg_i(cfg_chg), .drv_valid_i(pad_drv_valid), .drv_pin_i(pad_drv_pin),
    .drv_level_i(pad_drv_level), .release_i(pad_release),
    .conn_o(conn), .high_o(high)
  );

  gpio_resolver u_res (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .otype_i(otype), .pull_i(pull),
    .odr_i(odr), .conn_i(conn), .high_i(high), .idr_o(idr)
  );

  assign pad_level = idr;
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam logic [31:0] P_MODE  = 32'hFFFF_FF00;
  localparam logic [31:0] P_SPEED = 32'h0C00_0000;
  localparam logic [31:0] P_PULL  = 32'h0000_0064;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_err;
  logic        pad_drv_valid = 1'b0, pad_drv_level = 1'b0;
  logic [3:0]  pad_drv_pin = '0;
  logic [15:0] pad_release = '0, pad_level;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_port #(.AW(10), .MODE_RST(P_MODE), .SPEED_RST(P_SPEED), .PULL_RST(P_PULL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pad_drv_valid(pad_drv_valid), .pad_drv_pin(pad_drv_pin),
    .pad_drv_level(pad_drv_level), .pad_release(pad_release), .pad_level(pad_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic drive(input int pin, input logic lvl);
    @(negedge clk);
    pad_drv_valid = 1; pad_drv_pin = 4'(pin); pad_drv_level = lvl;
    @(negedge clk);
    pad_drv_valid = 0;
  endtask

  task automatic rel(input logic [15:0] m);
    @(negedge clk);
    pad_release = m;
    @(negedge clk);
    pad_release = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] keep_mask(input int idx);
    return (idx == 1 || idx == 5 || idx == 7 || idx == 11) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [15:0] setclr(input logic [15:0] o, input logic [31:0] v);
    return (o & ~v[31:16]) | v[15:0];
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    logic [15:0] odr_m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();

    // R1 reset state
    chk("R1 err", {31'b0, bus_err}, 0);
    rd(10'h00, d); chk("R1 mode", d, P_MODE);
    rd(10'h08, d); chk("R1 speed", d, P_SPEED);
    rd(10'h0C, d); chk("R1 pull", d, P_PULL);
    rd(10'h04, d); chk("R1 otype", d, 0);
    rd(10'h14, d); chk("R1 odr", d, 0);
    rd(10'h1C, d); chk("R1 lock", d, 0);
    rd(10'h20, d); chk("R1 aflo", d, 0);
    rd(10'h2C, d); chk("R1 asw", d, 0);
    // R8 pulls on undriven inputs: pins 1,3 up, pin 2 down
    rd(10'h10, d); chk("R8 reset pulls", d, 32'h0000_000A);
    chk("R8 pad_level", {16'b0, pad_level}, 32'h0000_000A);

    // R2 random store/readback with masking
    for (int i = 0; i < 24; i++) begin
      int idx;
      idx = int'($urandom_range(0, 5));
      case (idx)
        0: idx = 1; 1: idx = 2; 2: idx = 5; 3: idx = 7; 4: idx = 8; default: idx = 11;
      endcase
      if (i % 6 == 5) idx = (i % 12 == 5) ? 9 : 3;
      v = $urandom;
      wr(10'(4 * idx), v);
      rd(10'(4 * idx), d);
      chk("R2 readback", d, v & keep_mask(idx));
    end

    // R3 set/clear with set priority
    wr(10'h14, 32'h0);
    wr(10'h18, 32'h0001_0001);
    rd(10'h14, d); chk("R3 set wins", d, 32'h1);
    rd(10'h18, d); chk("R3 reads zero", d, 0);
    for (int i = 0; i < 12; i++) begin
      odr_m = 16'($urandom);
      wr(10'h14, {16'hFFFF, odr_m});
      v = $urandom;
      wr(10'h18, v);
      rd(10'h14, d); chk("R3 random", d, {16'h0, setclr(odr_m, v)});
    end

    // R4 clear-only
    for (int i = 0; i < 6; i++) begin
      odr_m = 16'($urandom);
      wr(10'h14, {16'h0, odr_m});
      v = $urandom;
      wr(10'h28, v);
      rd(10'h14, d); chk("R4 clear", d, {16'h0, odr_m & ~v[15:0]});
    end
    rd(10'h28, d); chk("R4 reads zero", d, 0);

    // R5 input register read-only
    wr(10'h0C, 32'h0); wr(10'h00, 32'h0); wr(10'h14, 32'h0000_1234);
    settle();
    rd(10'h10, v);
    wr(10'h10, 32'hFFFF_FFFF);
    settle();
    rd(10'h10, d); chk("R5 idr unchanged", d, v);
    rd(10'h14, d); chk("R5 odr unchanged", d, 32'h1234);

    // R6 illegal accesses
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 10'h15; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    chk("R6 err raised", {31'b0, bus_err}, 1);
    @(negedge clk);
    chk("R6 err one cycle", {31'b0, bus_err}, 0);
    rd(10'h14, d); chk("R6 misaligned write dropped", d, 32'h1234);
    wr(10'h00, 32'h5555_5555);
    rd(10'h01, d); chk("R6 misaligned read", d, 0);
    rd(10'h30, d); chk("R6 unmapped read", d, 0);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 10'h3FC;
    @(negedge clk);
    bus_sel = 0;
    chk("R6 far err", {31'b0, bus_err}, 1);

    // R7 output resolution
    v = $urandom;
    wr(10'h04, 32'h0); wr(10'h14, v);
    settle();
    rd(10'h10, d); chk("R7 push-pull", d, {16'h0, v[15:0]});
    wr(10'h04, 32'hFFFF); wr(10'h0C, 32'h5555_5555); wr(10'h14, 32'hF0F0);
    settle();
    rd(10'h10, d); chk("R7 open-drain pull-up", d, 32'hF0F0);
    wr(10'h0C, 32'hAAAA_AAAA);
    settle();
    rd(10'h10, d); chk("R7 open-drain pull-down", d, 0);
    wr(10'h0C, 32'h5555_5555);
    drive(4, 1'b0);
    settle();
    rd(10'h10, d); chk("R7 open-drain held low", d, 32'hF0E0);

    // R10 switch to push-pull detaches pin 4
    wr(10'h04, 32'h0);
    settle();
    rd(10'h10, d); chk("R7 push-pull again", d, 32'hF0F0);
    wr(10'h0C, 32'h0); wr(10'h00, 32'h0);
    settle();
    rd(10'h10, d); chk("R10 pin4 detached", d, 32'hF0F0);

    // R9 drive refused on push-pull output
    wr(10'h00, 32'h5555_5555); wr(10'h14, 32'h0);
    settle();
    drive(7, 1'b1);
    wr(10'h00, 32'h0);
    settle();
    rd(10'h10, d); chk("R9 refused drive", d, 0);

    // R8 attached input, then R10 detaches on mode change
    drive(6, 1'b1);
    settle();
    rd(10'h10, d); chk("R8 driven input", d, 32'h0040);
    wr(10'h00, 32'h0000_1000);
    settle();
    rd(10'h10, d); chk("R7 pin6 output", d, 0);
    wr(10'h00, 32'h0);
    settle();
    rd(10'h10, d); chk("R10 pin6 detached", d, 0);

    // R11 release with pull-down
    wr(10'h0C, 32'h0002_0000);
    drive(8, 1'b1);
    settle();
    rd(10'h10, d); chk("R11 before release", d, 32'h0100);
    rel(16'h0100);
    settle();
    rd(10'h10, d); chk("R11 after release", d, 0);

    // R8 floating pin keeps level
    wr(10'h0C, 32'h0);
    drive(9, 1'b1);
    settle();
    rel(16'h0200);
    settle();
    rd(10'h10, d); chk("R8 floating holds", d, 32'h0200);
    drive(9, 1'b0);
    settle();
    rd(10'h10, d); chk("R8 driven low", d, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule